// File: doc/BRIEF.md
# Dual-Modulus Swallow-Counter Clock Divider

This block divides its clock by a programmable integer N. A prescaler counts input cycles in groups of P or P+1. A program counter counts B prescaler groups per output period. A swallow counter sets how many of those groups use the longer P+1 length. The total ratio is N = P·B + A. The same datapath also covers three fixed prescaler ratios and a bypass of the program counter. Each output period ends with a single-cycle pulse on `div_out_o`.

Configuration is taken only at the boundary between output periods, so settings can be rewritten at any time without producing a distorted period. An illegal combination raises `cfg_err_o` and silences the output until a legal setting arrives. Two software-style level resets and an optional external sync input restart the count. The sync input can act on its level, its rising edge or its falling edge.

Top module: `swallow_fbdiv`

## Requirements
- R1: Modes 3, 4, 5, 6 and 7 are dual-modulus with P = 2, 4, 8, 16 and 32. For B ≥ 3 and A < B, the period is N = P·B + A input cycles. The first A prescaler groups of each period last P+1 cycles and the rest last P.
- R2: Modes 0, 1 and 2 are fixed prescaler ratios f = 1, 2 and 3. For B ≥ 3, the period is f·B. The value on `a_i` is ignored and counts as zero.
- R3: B = 1 bypasses the program counter. The period then equals the prescaler ratio alone: 1, 2 or 3 in modes 0 to 2, and P in modes 3 to 7.
- R4: The following settings are illegal: B = 0, B = 2, dual-modulus with B ≥ 3 and A ≥ B, and dual-modulus with B = 1 and A ≠ 0. When such a setting is loaded, `cfg_err_o` is high from the loading edge onward and `div_out_o` stays low. Legal settings keep `cfg_err_o` low.
- R5: While in error, the inputs are re-sampled on every clock edge. When a legal setting is loaded, `cfg_err_o` falls at that edge. The first pulse follows N edges later.
- R6: `div_out_o` is high for one cycle per period and low for the other N−1 cycles. For N = 1 it stays high.
- R7: Mode, A and B are sampled only at the edge that ends a period. A change made mid-period takes effect only in the next period.
- R8: While `cnt_rst_i` or `shared_rst_i` is high, `div_out_o` and `cfg_err_o` are low. Counting restarts from the first edge at which both are low (the load edge). The first pulse then appears at the N-th rising edge after the load edge.
- R9: With `sync_mode_i` = 0, `sync_i` has no effect.
- R10: With `sync_mode_i` = 1, a high `sync_i` acts like the level resets of R8, with the same restart timing.
- R11: With `sync_mode_i` = 2 or 3, a rising or falling edge of `sync_i` clears the count for one cycle. A level held afterwards has no further effect. The first pulse then appears at the (N+1)-th rising edge after the detecting edge.
- R12: While `rst_ni` is low, `div_out_o` and `cfg_err_o` are low. The reset takes effect without waiting for a clock edge.

Mode encoding is a 3-bit `mode_i` as listed in R1 and R2. The sync modes are 0 off, 1 level, 2 rising edge and 3 falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock to be divided |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 3 | Prescaler mode (0–2 fixed, 3–7 dual-modulus) |
| a_i | input | A_W (6) | Swallow count A |
| b_i | input | B_W (13) | Program count B |
| cnt_rst_i | input | 1 | Level reset of the A/B counters |
| shared_rst_i | input | 1 | Shared level reset (counters and reference path) |
| sync_i | input | 1 | External synchronous sync input |
| sync_mode_i | input | 2 | Sync behaviour: off, level, rising, falling |
| div_out_o | output | 1 | One-cycle pulse per output period |
| cfg_err_o | output | 1 | Illegal configuration flag |

## Verification
The divider is run across every fixed ratio, every dual-modulus P, bypassed and unbypassed B, zero and maximal swallow counts, and a fixed mode with a nonzero A. Each run measures both the restart latency and consecutive periods. A swallow count that was dropped or applied to the wrong groups shows up as a period that is off by the number of P+1 groups. A mix-up between P and the fixed ratios changes the period by a whole multiple of B. Illegal settings, recovery and a mid-period rewrite separate period-boundary loading from loading on every cycle. The four sync behaviours are compared through their distinct restart latencies, N+1 against N+2 counted from the stimulus.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;

  localparam int MODE_W = 3;
  localparam int PRE_W  = 6;

  localparam logic [MODE_W-1:0] MODE_FIRST_DUAL = 3'd3;

  typedef enum logic [1:0] {
    SYNC_OFF   = 2'd0,
    SYNC_LEVEL = 2'd1,
    SYNC_RISE  = 2'd2,
    SYNC_FALL  = 2'd3
  } sync_mode_e;

  function automatic logic is_dual(input logic [MODE_W-1:0] m);
    return (m >= MODE_FIRST_DUAL);
  endfunction

  // Shorter prescaler length: P for dual-modulus modes, f for fixed modes.
  function automatic logic [PRE_W-1:0] base_ratio(input logic [MODE_W-1:0] m);
    if (is_dual(m)) begin
      return PRE_W'(1) << (m - MODE_FIRST_DUAL + 3'd1);
    end
    return PRE_W'(m) + PRE_W'(1);
  endfunction

endpackage

// File: rtl/swdiv_rst_sync.sv
module swdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/swdiv_cfg_shadow.sv
module swdiv_cfg_shadow
  import swdiv_pkg::*;
#(
  parameter int A_W = 6,
  parameter int B_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              period_end_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [A_W-1:0]    a_i,
  input  logic [B_W-1:0]    b_i,
  output logic [MODE_W-1:0] mode_o,
  output logic [A_W-1:0]    a_o,
  output logic [B_W-1:0]    b_o,
  output logic              armed_o,
  output logic              err_o
);

  logic [MODE_W-1:0] mode_q, mode_d;
  logic [A_W-1:0]    a_q, a_d;
  logic [B_W-1:0]    b_q, b_d;
  logic              armed_q, armed_d;
  logic              err_q, err_d;

  logic              in_dual;
  logic              b_bypass;
  logic              b_ok;
  logic              a_ok;
  logic              legal;
  logic [A_W-1:0]    a_eff;
  logic              load;

  // Legality of the values presented on the inputs.
  always_comb begin
    in_dual  = is_dual(mode_i);
    b_bypass = (b_i == B_W'(1));
    b_ok     = b_bypass | (b_i >= B_W'(3));
    if (!in_dual) begin
      a_ok = 1'b1;
    end else if (b_bypass) begin
      a_ok = (a_i == '0);
    end else begin
      a_ok = (B_W'(a_i) < b_i);
    end
    legal = b_ok & a_ok;
    a_eff = in_dual ? a_i : '0;
    load  = ~armed_q | period_end_i;
  end

  always_comb begin
    mode_d  = mode_q;
    a_d     = a_q;
    b_d     = b_q;
    armed_d = armed_q;
    err_d   = err_q;
    if (clr_i) begin
      armed_d = 1'b0;
      err_d   = 1'b0;
    end else if (load) begin
      mode_d  = mode_i;
      a_d     = a_eff;
      b_d     = b_i;
      armed_d = legal;
      err_d   = ~legal;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      a_q     <= '0;
      b_q     <= '0;
      armed_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      a_q     <= a_d;
      b_q     <= b_d;
      armed_q <= armed_d;
      err_q   <= err_d;
    end
  end

  assign mode_o  = mode_q;
  assign a_o     = a_q;
  assign b_o     = b_q;
  assign armed_o = armed_q;
  assign err_o   = err_q;

  AST_ERR_DISARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> !armed_q); // R4

  AST_SHADOW_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !period_end_i) |=> ($stable(mode_q) && $stable(a_q) && $stable(b_q))); // R7

endmodule

// File: rtl/swdiv_prescaler.sv
module swdiv_prescaler
  import swdiv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              swallow_i,
  output logic              tick_o
);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W-1:0] modulus;
  logic             tick;

  always_comb begin
    modulus = base_ratio(mode_i) + PRE_W'(swallow_i);
    tick    = run_i & (pre_q == (modulus - PRE_W'(1)));
    if (!run_i || tick) begin
      pre_d = '0;
    end else begin
      pre_d = pre_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_d;
    end
  end

  assign tick_o = tick;

  AST_PRE_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (pre_q < modulus)); // R1

endmodule

// File: rtl/swdiv_swallow_core.sv
module swdiv_swallow_core #(
  parameter int A_W = 6,
  parameter int B_W = 13
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic           tick_i,
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  output logic           swallow_o,
  output logic           period_end_o
);

  logic [A_W-1:0] acnt_q, acnt_d;
  logic [B_W-1:0] bcnt_q, bcnt_d;
  logic           swallow;
  logic           last_group;
  logic           period_end;

  always_comb begin
    swallow    = (acnt_q != a_i);
    last_group = (bcnt_q == (b_i - B_W'(1)));
    period_end = tick_i & last_group;
    acnt_d     = acnt_q;
    bcnt_d     = bcnt_q;
    if (!run_i || period_end) begin
      acnt_d = '0;
      bcnt_d = '0;
    end else if (tick_i) begin
      bcnt_d = bcnt_q + B_W'(1);
      if (swallow) begin
        acnt_d = acnt_q + A_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acnt_q <= '0;
      bcnt_q <= '0;
    end else begin
      acnt_q <= acnt_d;
      bcnt_q <= bcnt_d;
    end
  end

  assign swallow_o    = swallow;
  assign period_end_o = period_end;

  AST_B_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (bcnt_q < b_i)); // R1

  AST_A_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (acnt_q <= a_i)); // R1

endmodule

// File: rtl/swallow_fbdiv.sv
module swallow_fbdiv
  import swdiv_pkg::*;
#(
  parameter int A_W        = 6,
  parameter int B_W        = 13,
  parameter int RST_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [A_W-1:0]    a_i,
  input  logic [B_W-1:0]    b_i,
  input  logic              cnt_rst_i,
  input  logic              shared_rst_i,
  input  logic              sync_i,
  input  logic [1:0]        sync_mode_i,
  output logic              div_out_o,
  output logic              cfg_err_o
);

  logic              rst_n;
  logic              sync_q, sync_d;
  logic              sync_hit;
  logic              clr;
  logic              run;
  logic              pulse_q, pulse_d;

  logic [MODE_W-1:0] mode_s;
  logic [A_W-1:0]    a_s;
  logic [B_W-1:0]    b_s;
  logic              armed;
  logic              err;
  logic              swallow;
  logic              tick;
  logic              period_end;

  swdiv_rst_sync #(
    .STAGES (RST_STAGES)
  ) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  // Sync qualification and restart request.
  always_comb begin
    sync_d = sync_i;
    unique case (sync_mode_e'(sync_mode_i))
      SYNC_OFF:   sync_hit = 1'b0;
      SYNC_LEVEL: sync_hit = sync_i;
      SYNC_RISE:  sync_hit = sync_i & ~sync_q;
      SYNC_FALL:  sync_hit = ~sync_i & sync_q;
      default:    sync_hit = 1'b0;
    endcase
    clr     = cnt_rst_i | shared_rst_i | sync_hit;
    run     = armed & ~clr;
    pulse_d = period_end;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      sync_q  <= sync_d;
      pulse_q <= pulse_d;
    end
  end

  swdiv_cfg_shadow #(
    .A_W (A_W),
    .B_W (B_W)
  ) u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .clr_i        (clr),
    .period_end_i (period_end),
    .mode_i       (mode_i),
    .a_i          (a_i),
    .b_i          (b_i),
    .mode_o       (mode_s),
    .a_o          (a_s),
    .b_o          (b_s),
    .armed_o      (armed),
    .err_o        (err)
  );

  swdiv_prescaler u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .run_i     (run),
    .mode_i    (mode_s),
    .swallow_i (swallow),
    .tick_o    (tick)
  );

  swdiv_swallow_core #(
    .A_W (A_W),
    .B_W (B_W)
  ) u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .run_i        (run),
    .tick_i       (tick),
    .a_i          (a_s),
    .b_i          (b_s),
    .swallow_o    (swallow),
    .period_end_o (period_end)
  );

  assign div_out_o = pulse_q;
  assign cfg_err_o = err;

  AST_SILENT_AFTER_ERR: assert property (@(posedge clk_i) disable iff (!rst_n)
    cfg_err_o |=> !div_out_o); // R4

  AST_LEVEL_RST_SILENCES: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cnt_rst_i || shared_rst_i) |=> (!div_out_o && !cfg_err_o)); // R8

  AST_SYNC_OFF_NO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_n)
    (sync_mode_i == 2'd0 && !cnt_rst_i && !shared_rst_i && armed && !period_end) |=> armed); // R9

endmodule

// File: tb/swallow_fbdiv_tb_top.sv
`timescale 1ns/1ps
module swallow_fbdiv_tb_top;

  localparam int A_W = 6;
  localparam int B_W = 13;
  localparam int NV  = 14;
  localparam int LIM = 2000;

  // {req[1:0], mode[2:0], b[12:0], a[5:0], n[19:0]}
  localparam logic [43:0] VECS [NV] = '{
    {2'd3, 3'd0, 13'd1,  6'd0,  20'd1},
    {2'd3, 3'd1, 13'd1,  6'd0,  20'd2},
    {2'd3, 3'd2, 13'd1,  6'd0,  20'd3},
    {2'd3, 3'd3, 13'd1,  6'd0,  20'd2},
    {2'd3, 3'd7, 13'd1,  6'd0,  20'd32},
    {2'd2, 3'd2, 13'd5,  6'd0,  20'd15},
    {2'd2, 3'd0, 13'd3,  6'd0,  20'd3},
    {2'd2, 3'd2, 13'd5,  6'd7,  20'd15},
    {2'd1, 3'd3, 13'd3,  6'd2,  20'd8},
    {2'd1, 3'd4, 13'd6,  6'd0,  20'd24},
    {2'd1, 3'd5, 13'd10, 6'd9,  20'd89},
    {2'd1, 3'd6, 13'd4,  6'd3,  20'd67},
    {2'd1, 3'd7, 13'd20, 6'd19, 20'd659},
    {2'd1, 3'd4, 13'd3,  6'd1,  20'd13}
  };

  logic           clk;
  logic           rst_n;
  logic [2:0]     mode;
  logic [A_W-1:0] a;
  logic [B_W-1:0] b;
  logic           cnt_rst;
  logic           shared_rst;
  logic           sync;
  logic [1:0]     sync_mode;
  logic           div_out;
  logic           cfg_err;

  int n_checks = 0;
  int n_errors = 0;

  swallow_fbdiv dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .mode_i       (mode),
    .a_i          (a),
    .b_i          (b),
    .cnt_rst_i    (cnt_rst),
    .shared_rst_i (shared_rst),
    .sync_i       (sync),
    .sync_mode_i  (sync_mode),
    .div_out_o    (div_out),
    .cfg_err_o    (cfg_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic string req_name(input int code);
    case (code)
      1: return "R1";
      2: return "R2";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Negedges until div_out is seen high; -1 on timeout.
  task automatic count_to_pulse(output int cnt);
    cnt = -1;
    for (int i = 1; i <= LIM; i++) begin
      @(negedge clk);
      if (div_out) begin
        cnt = i;
        break;
      end
    end
  endtask

  // Apply a setting under shared reset and release it at a negedge.
  task automatic restart(input logic [2:0] m, input logic [B_W-1:0] bb, input logic [A_W-1:0] aa);
    @(negedge clk);
    mode = m; b = bb; a = aa; shared_rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 output low while shared reset held", int'(div_out), 0);
    shared_rst = 1'b0;
  endtask

  task automatic expect_silent(input string req, input int cycles);
    int hits;
    hits = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (div_out) hits++;
    end
    chk(req, hits, 0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    int cnt;
    rst_n = 1'b0; mode = 3'd0; a = '0; b = 13'd1;
    cnt_rst = 1'b0; shared_rst = 1'b0; sync = 1'b0; sync_mode = 2'd0;
    repeat (4) @(negedge clk);
    chk("R12 div_out low in reset", int'(div_out), 0);
    chk("R12 cfg_err low in reset", int'(cfg_err), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // Table of settings: latency, two periods, error flag.
    for (int v = 0; v < NV; v++) begin
      logic [43:0] e;
      int n;
      string rq;
      e  = VECS[v];
      n  = int'(e[19:0]);
      rq = req_name(int'(e[43:42]));
      restart(e[41:39], e[38:26], e[25:20]);
      count_to_pulse(cnt);
      chk("R8 restart latency", cnt, n + 1);
      chk("R4 legal setting keeps error low", int'(cfg_err), 0);
      count_to_pulse(cnt);
      chk({rq, " R6 period 1"}, cnt, n);
      count_to_pulse(cnt);
      chk({rq, " R6 period 2"}, cnt, n);
    end

    // Illegal settings (R4).
    restart(3'd4, 13'd2, 6'd0);
    @(negedge clk); chk("R4 B=2 flags error", int'(cfg_err), 1);
    expect_silent("R4 B=2 output silent", 60);
    restart(3'd4, 13'd0, 6'd0);
    @(negedge clk); chk("R4 B=0 flags error", int'(cfg_err), 1);
    expect_silent("R4 B=0 output silent", 40);
    restart(3'd5, 13'd5, 6'd5);
    @(negedge clk); chk("R4 A equal to B flags error", int'(cfg_err), 1);
    expect_silent("R4 A equal to B output silent", 60);
    restart(3'd3, 13'd1, 6'd1);
    @(negedge clk); chk("R4 bypass with nonzero A flags error", int'(cfg_err), 1);
    expect_silent("R4 bypass with nonzero A output silent", 40);

    // Recovery (R5): legal P=2, B=3, A=1 -> N=7.
    mode = 3'd3; b = 13'd3; a = 6'd1;
    @(negedge clk); chk("R5 error clears on legal load", int'(cfg_err), 0);
    count_to_pulse(cnt);
    chk("R5 first pulse after recovery", cnt, 7);

    // Mid-period rewrite (R7): N=24 then N=8.
    restart(3'd4, 13'd6, 6'd0);
    count_to_pulse(cnt);
    chk("R8 latency N=24", cnt, 25);
    repeat (2) @(negedge clk);
    mode = 3'd3; b = 13'd3; a = 6'd2;
    count_to_pulse(cnt);
    chk("R7 current period keeps old setting", cnt, 22);
    count_to_pulse(cnt);
    chk("R7 next period uses new setting", cnt, 8);

    // Counter reset input (R8).
    restart(3'd0, 13'd3, 6'd0);
    count_to_pulse(cnt);
    @(negedge clk); cnt_rst = 1'b1;
    expect_silent("R8 counter reset silences output", 10);
    chk("R8 error low under counter reset", int'(cfg_err), 0);
    cnt_rst = 1'b0;
    count_to_pulse(cnt);
    chk("R8 latency after counter reset", cnt, 4);

    // Sync behaviours on N=15.
    restart(3'd2, 13'd5, 6'd0);
    count_to_pulse(cnt);
    repeat (3) @(negedge clk);
    sync = 1'b1;
    repeat (2) @(negedge clk);
    sync = 1'b0;
    count_to_pulse(cnt);
    chk("R9 sync ignored when off", cnt, 10);

    sync_mode = 2'd1;
    @(negedge clk); sync = 1'b1;
    expect_silent("R10 level sync holds output low", 20);
    sync = 1'b0;
    count_to_pulse(cnt);
    chk("R10 latency after level sync", cnt, 16);

    sync_mode = 2'd2;
    @(negedge clk); sync = 1'b1;
    count_to_pulse(cnt);
    chk("R11 latency after rising sync", cnt, 17);
    count_to_pulse(cnt);
    chk("R11 held level does not retrigger", cnt, 15);

    sync_mode = 2'd0;
    @(negedge clk); sync_mode = 2'd3;
    @(negedge clk); sync = 1'b0;
    count_to_pulse(cnt);
    chk("R11 latency after falling sync", cnt, 17);
    sync_mode = 2'd0;

    // Asynchronous reset while output is constantly high (R12).
    restart(3'd0, 13'd1, 6'd0);
    count_to_pulse(cnt);
    chk("R3 N=1 latency", cnt, 2);
    @(negedge clk);
    chk("R6 N=1 stays high", int'(div_out), 1);
    rst_n = 1'b0;
    #1;
    chk("R12 async reset clears output", int'(div_out), 0);
    chk("R12 async reset clears error", int'(cfg_err), 0);

    summary();
    $finish;
  end

endmodule